// File: doc/BRIEF.md
# Read Response Line Transmitter

This block sits at the far end of a chain of cores that share a 16-bit memory bus. It watches each completed bus transaction. For every read, it builds one reply line in plain ASCII and hands it, one byte at a time, to a byte-wide transmitter downstream. Writes pass without any reply.

A reply line is seven bytes long. It has the same length as a read request, with the read data in the place of the address. The line starts with an uppercase `R`. Four hex characters of the read data follow, most significant nibble first. A carriage return and a line feed close the line.

The read data is captured at the moment the transaction completes. Reads that arrive while a line is still going out wait in a small queue. Reads that find the queue full are discarded.

Bytes leave through a valid/ready handshake. A byte moves only on a clock edge where both `txValid` and `txReady` are high.

Top module: `rd_resp_tx`

## Requirements
- R1: A read (busValid high, busRw low) produces exactly seven bytes: 0x52 ('R'), four hex characters of busData with the most significant nibble first, then 0x0D and 0x0A. Nothing more follows unless another read arrives.
- R2: Hex characters encode nibble values 0 to 9 as 0x30 to 0x39 and values 10 to 15 as uppercase 0x41 to 0x46.
- R3: A write (busValid high, busRw high) produces no byte: txValid stays low when the block is otherwise idle.
- R4: A byte leaves only on an edge with txReady high. While txValid is high and txReady is low, txValid stays high and txData is unchanged on the next cycle.
- R5: The data of a read is captured on the edge where that read is sampled. Later values on busData, or later writes, do not change the line.
- R6: While a line is being sent, up to QUEUE_DEPTH (default 2) further reads are held. They are sent in arrival order.
- R7: A read that arrives while the queue already holds QUEUE_DEPTH entries is dropped and produces no line.
- R8: While rstN is low, txValid is low.
- R9: When a queued read is waiting, its 'R' is offered in the cycle right after the previous line's 0x0A is accepted, with no idle cycle.
- R10: From an idle, empty state, txValid rises in the second cycle after the edge that samples a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus transaction completes this cycle |
| busRw | input | 1 | Low for a read, high for a write |
| busData | input | 16 | Read data (or write data) on the bus |
| txReady | input | 1 | Downstream transmitter can accept a byte |
| txValid | output | 1 | txData holds a byte to send |
| txData | output | 8 | Byte offered to the transmitter |

## Verification
The read is sampled on edge E1 and written into the queue there. Edge E2 moves it into the output register, so the 'R' shows from the cycle after E2, and the bench checks that txValid is still low one cycle after E1. Every later byte appears one cycle after the edge that accepted the byte before it.

The bench drives inputs and samples outputs on falling edges. It checks one byte per falling edge while txReady is held high. This pins down both the byte order and the absence of gaps between queued lines. Stall windows check the held byte on every cycle. Drop and write cases check, cycle by cycle, that no unexpected byte appears.

// File: rtl/rd_resp_pkg.sv
package rd_resp_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIBBLES  = WORD_W / 4;
  localparam int unsigned LINE_LEN = NIBBLES + 3;
  localparam int unsigned IDX_W    = $clog2(LINE_LEN);

  localparam logic [BYTE_W-1:0] CHAR_HEAD = 8'h52;
  localparam logic [BYTE_W-1:0] CHAR_CR   = 8'h0D;
  localparam logic [BYTE_W-1:0] CHAR_LF   = 8'h0A;

  typedef struct packed {
    logic push;  // store the current bus read in the queue
    logic pop;   // move the queue head into the output word
  } ctrlStrobes_t;

  function automatic logic [BYTE_W-1:0] hexChar(input logic [3:0] nib);
    if (nib < 4'd10) hexChar = 8'h30 + {4'h0, nib};
    else             hexChar = 8'h37 + {4'h0, nib};
  endfunction

endpackage

// File: rtl/rd_resp_datapath.sv
module rd_resp_datapath
  import rd_resp_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [WORD_W-1:0]  busData,
  input  logic [IDX_W-1:0]   byteIdx,
  output logic               fifoEmpty,
  output logic               fifoFull,
  output logic [BYTE_W-1:0]  txData
);

  localparam int unsigned PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic [WORD_W-1:0] queueMem [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  fillCount;
  logic [WORD_W-1:0] curWord;

  assign fifoEmpty = (fillCount == '0);
  assign fifoFull  = (fillCount == CNT_W'(QUEUE_DEPTH));

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(QUEUE_DEPTH - 1)) nextPtr = '0;
    else                              nextPtr = p + 1'b1;
  endfunction

  // Queue storage: one register per entry
  for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobes.push && (wrPtr == PTR_W'(e))) queueMem[e] <= busData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      curWord   <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop) begin
        rdPtr   <= nextPtr(rdPtr);
        curWord <= queueMem[rdPtr];
      end
      case ({strobes.push, strobes.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // Byte selection for the line being sent
  logic [WORD_W-1:0] shiftedWord;
  always_comb begin
    shiftedWord = curWord >> (WORD_W - 4 * {28'd0, byteIdx});
    if (byteIdx == '0)                       txData = CHAR_HEAD;
    else if (byteIdx <= IDX_W'(NIBBLES))     txData = hexChar(shiftedWord[3:0]);
    else if (byteIdx == IDX_W'(NIBBLES + 1)) txData = CHAR_CR;
    else                                     txData = CHAR_LF;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(QUEUE_DEPTH)); // R6

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> !fifoEmpty); // R6

  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && !strobes.pop |=> fillCount == CNT_W'(QUEUE_DEPTH)); // R7

endmodule

// File: rtl/rd_resp_control.sv
module rd_resp_control
  import rd_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busRw,
  input  logic              txReady,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic [BYTE_W-1:0] txData,
  output ctrlStrobes_t      strobes,
  output logic [IDX_W-1:0]  byteIdx,
  output logic              txValid
);

  typedef enum logic { ST_IDLE, ST_SEND } txState_t;

  txState_t state;
  logic     lastByte;
  logic     handoff;

  assign lastByte = (byteIdx == IDX_W'(LINE_LEN - 1));
  assign handoff  = txValid && txReady;
  assign txValid  = (state == ST_SEND);

  always_comb begin
    strobes.push = busValid && !busRw && !fifoFull;
    strobes.pop  = !fifoEmpty &&
                   ((state == ST_IDLE) || (handoff && lastByte));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!fifoEmpty) begin
            state   <= ST_SEND;
            byteIdx <= '0;
          end
        end
        ST_SEND: begin
          if (handoff) begin
            if (lastByte) begin
              byteIdx <= '0;
              state   <= fifoEmpty ? ST_IDLE : ST_SEND;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData)); // R4

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> txData == CHAR_HEAD); // R1

  AST_LF_AFTER_CR: assert property (@(posedge clk) disable iff (!rstN)
    handoff && txData == CHAR_CR |=> txValid && txData == CHAR_LF); // R1

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busRw && !txValid && fifoEmpty |=> !txValid); // R3

endmodule

// File: rtl/rd_resp_tx.sv
module rd_resp_tx
  import rd_resp_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busRw,
  input  logic [WORD_W-1:0] busData,
  input  logic              txReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] byteIdx;
  logic             fifoEmpty;
  logic             fifoFull;

  rd_resp_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busRw     (busRw),
    .txReady   (txReady),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .txData    (txData),
    .strobes   (strobes),
    .byteIdx   (byteIdx),
    .txValid   (txValid)
  );

  rd_resp_datapath #(.QUEUE_DEPTH(QUEUE_DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busData   (busData),
    .byteIdx   (byteIdx),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .txData    (txData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !txValid); // R8

endmodule

// File: tb/rd_resp_tx_tb_top.sv
`timescale 1ns/1ps
module rd_resp_tx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busRw = 1'b0;
  logic [15:0] busData = 16'h0;
  logic        txReady = 1'b0;
  logic        txValid;
  logic [7:0]  txData;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  rd_resp_tx dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busRw    (busRw),
    .busData  (busData),
    .txReady  (txReady),
    .txValid  (txValid),
    .txData   (txData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hexOf(input logic [3:0] n);
    return (n < 10) ? (8'd48 + n) : (8'd65 + n - 8'd10);
  endfunction

  function automatic logic [7:0] lineByte(input logic [15:0] w, input int i);
    case (i)
      0: return 8'h52;
      1: return hexOf(w[15:12]);
      2: return hexOf(w[11:8]);
      3: return hexOf(w[7:4]);
      4: return hexOf(w[3:0]);
      5: return 8'h0D;
      default: return 8'h0A;
    endcase
  endfunction

  // Caller is at the falling edge where byte 0 is offered, txReady high.
  task automatic collectLine(input logic [15:0] w, input string req);
    for (int i = 0; i < 7; i++) begin
      if (i > 0) @(negedge clk);
      chk({req, " valid"}, {15'd0, txValid}, 16'd1);
      chk({req, " byte"}, {8'd0, txData}, {8'd0, lineByte(w, i)});
    end
  endtask

  task automatic tReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 valid low in reset", {15'd0, txValid}, 16'd0);
    end
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {15'd0, txValid}, 16'd0);
  endtask

  task automatic tSingle(input logic [15:0] w, input string req);
    txReady = 1'b1;
    busValid = 1'b1; busRw = 1'b0; busData = w;
    @(negedge clk);
    busValid = 1'b0; busData = 16'h0;
    chk("R10 not yet valid", {15'd0, txValid}, 16'd0);
    @(negedge clk);
    collectLine(w, req);
    @(negedge clk);
    chk("R1 line ends after LF", {15'd0, txValid}, 16'd0);
  endtask

  task automatic tWrite();
    txReady = 1'b1;
    busValid = 1'b1; busRw = 1'b1; busData = 16'hBEEF;
    @(negedge clk);
    busValid = 1'b0; busRw = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R3 write silent", {15'd0, txValid}, 16'd0);
      @(negedge clk);
    end
  endtask

  task automatic tStall();
    txReady = 1'b0;
    busValid = 1'b1; busRw = 1'b0; busData = 16'h1234;
    @(negedge clk);
    busRw = 1'b1; busData = 16'hFFFF;   // write behind the read
    @(negedge clk);
    busValid = 1'b0; busRw = 1'b0; busData = 16'hAAAA;
    for (int i = 0; i < 5; i++) begin
      chk("R4 held valid", {15'd0, txValid}, 16'd1);
      chk("R4 held byte", {8'd0, txData}, 16'h0052);
      @(negedge clk);
    end
    txReady = 1'b1;
    collectLine(16'h1234, "R5 captured data");
    @(negedge clk);
    chk("R3 no line for write", {15'd0, txValid}, 16'd0);
    busData = 16'h0;
  endtask

  task automatic tQueue();
    txReady = 1'b0;
    busValid = 1'b1; busRw = 1'b0; busData = 16'h1A2B;
    @(negedge clk);
    busData = 16'h3C4D;
    @(negedge clk);
    busData = 16'h5E6F;
    @(negedge clk);
    busData = 16'h7788;                 // queue full: dropped
    @(negedge clk);
    busValid = 1'b0; busData = 16'h0;
    txReady = 1'b1;
    collectLine(16'h1A2B, "R6 first");
    @(negedge clk);
    collectLine(16'h3C4D, "R9 second no gap");
    @(negedge clk);
    collectLine(16'h5E6F, "R6 third in order");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 dropped read silent", {15'd0, txValid}, 16'd0);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    tReset();
    tSingle(16'h5678, "R1 line 5678");
    tSingle(16'hABCD, "R2 letters");
    tSingle(16'h09F0, "R2 mixed");
    tSingle(16'hFFFF, "R2 all F");
    tWrite();
    tStall();
    tQueue();
    tSingle(16'h0000, "R1 zero");
    summary();
    $finish;
  end

endmodule